// File: doc/BRIEF.md
# Transmit Block Priority Arbiter

This block chooses which block goes out on a serial lane in each block slot. Eight sources compete: clock compensation, not-ready, channel bonding, native flow control, user flow control (one header block followed by its data blocks), user K-blocks, frame data and idle. The choice is made once per slot, on a one-cycle slot tick. It is presented as a registered one-hot grant and a registered block-kind code that the block builder downstream uses to assemble the next block.

Two countdowns affect the choice. A native flow control block carries an 8-bit pause value, sent as a plain binary number. Once that block is granted, frame data is held off for that many slots, and the value 255 holds it off until a later native flow control block with a smaller value. A user flow control message keeps its source requesting until all its data blocks are sent. Higher-ranked blocks may cut in between them, and the message resumes afterwards. While either countdown runs, idle ranks above frame data.

Top module: `tx_blk_arbiter`

## Requirements
- R1: After synchronous reset, `grant` is 8'h80 (only the idle bit) and `blk_sel` is 8 (idle).
- R2: At each slot tick, the requesting source with the highest rank is granted. Ranks run clock compensation (grant bit 0, code 0), not-ready (bit 1, code 1), channel bonding (bit 2, code 2), native flow control (bit 3, code 3), user flow control (bit 4, code 4 for the header and 5 for a data block), user K-block (bit 5, code 6), frame data (bit 6, code 7) and idle (bit 7, code 8).
- R3: `grant` is always exactly one-hot. `grant` and `blk_sel` change only on the clock edge that samples `slot_tick` high, and they show the choice from the cycle after that edge until the next tick edge.
- R4: Idle is granted whenever no other source is requesting and no user flow control message is pending.
- R5: Granting a native flow control block with pause N (1 to 254) makes the next N slots refuse frame data; idle goes out instead. User K-blocks and all higher-ranked sources are still served in those slots, and the hold counts down in them too.
- R6: A native flow control block with pause 0 leaves frame data free in the very next slot.
- R7: Pause 255 holds off frame data with no time limit. A later native flow control block with a smaller pause replaces it.
- R8: `ufc_len` holds the message length in octets minus one (1 to 256 octets). A granted header (code 4) is followed by floor(ufc_len/8)+1 data blocks (code 5), and frame data is held off until the last of them has been sent.
- R9: A higher-ranked request that cuts into a user flow control message takes the slot. The count of remaining data blocks is kept, and the message resumes in the next free slot. `ufc_req` is ignored while a message is pending.
- R10: Only user K-block types 0 to 8 count as a request. With `ukb_type` 9 to 15, the user K-block request is ignored and the lower-ranked sources are served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_tick | input | 1 | One-cycle pulse marking a block slot boundary |
| cc_req | input | 1 | Clock compensation block wanted |
| nr_req | input | 1 | Not-ready block wanted |
| cb_req | input | 1 | Channel bonding block wanted |
| nfc_req | input | 1 | Native flow control block wanted |
| nfc_pause | input | 8 | Pause length for that block, in slots; 255 means indefinite |
| ufc_req | input | 1 | Start of a user flow control message wanted |
| ufc_len | input | 8 | Message length in octets minus one |
| ukb_req | input | 1 | User K-block wanted |
| ukb_type | input | 4 | User K-block type (0 to 8 valid) |
| data_req | input | 1 | Frame data block (data, separator or separator-7) ready |
| grant | output | 8 | One-hot grant for the current slot, bit 0 is highest rank |
| blk_sel | output | 4 | Kind of block selected for the current slot |

## Verification
A corrupt pause counter shows up as frame data granted inside a hold window, or as a hold that outlives its N slots. Either way it appears on `grant` bit 6 within one slot of the error. A wrong remaining-block count in the message tracker shows as too few or too many code-5 slots before frame data returns. This is seen when the message ends, and an interrupted message shows whether the count survived the cut-in. A broken priority chain or a register that updates without a tick makes `grant` and `blk_sel` disagree with the expected source on the first slot after the fault.

// File: rtl/tx_arb_pkg.sv
package tx_arb_pkg;

  localparam int N_SRC = 8;

  typedef enum logic [3:0] {
    BLK_CC      = 4'd0,
    BLK_NR      = 4'd1,
    BLK_CB      = 4'd2,
    BLK_NFC     = 4'd3,
    BLK_UFC_HDR = 4'd4,
    BLK_UFC_DAT = 4'd5,
    BLK_UKB     = 4'd6,
    BLK_DATA    = 4'd7,
    BLK_IDLE    = 4'd8
  } blk_e;

  // Map a source rank onto the block kind; the user flow control rank
  // splits into header or data block depending on whether a message is open.
  function automatic blk_e src_to_blk(input int idx, input logic ufc_open);
    case (idx)
      0:       return BLK_CC;
      1:       return BLK_NR;
      2:       return BLK_CB;
      3:       return BLK_NFC;
      4:       return ufc_open ? BLK_UFC_DAT : BLK_UFC_HDR;
      5:       return BLK_UKB;
      6:       return BLK_DATA;
      default: return BLK_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/tx_arb_pause.sv
module tx_arb_pause #(
  parameter int PAUSE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               load,
  input  logic [PAUSE_W-1:0] pause_val,
  output logic               hold
);
  localparam logic [PAUSE_W-1:0] XOFF = {PAUSE_W{1'b1}};

  logic [PAUSE_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (tick) begin
      if (load)
        cnt <= pause_val;
      else if (cnt != '0 && cnt != XOFF)
        cnt <= cnt - 1'b1;
    end
  end

  assign hold = (cnt != '0);

  // R7: an indefinite pause survives every slot without a new load
  assert_xoff_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && cnt == XOFF) |=> (cnt == XOFF));

  // R5: a running pause never jumps upward without a load
  assert_pause_down_R5: assert property (@(posedge clk) disable iff (rst)
    (!load) |=> (cnt <= $past(cnt)));

endmodule

// File: rtl/tx_arb_ufc.sv
module tx_arb_ufc #(
  parameter int LEN_W   = 8,
  parameter int BLK_OCT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             hdr_go,
  input  logic             dat_go,
  input  logic [LEN_W-1:0] len_m1,
  output logic             busy
);
  localparam int OCT_SH = $clog2(BLK_OCT);
  localparam int REM_W  = LEN_W - OCT_SH + 1;

  logic [REM_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (tick) begin
      if (hdr_go)
        remain <= REM_W'(len_m1 >> OCT_SH) + REM_W'(1);
      else if (dat_go)
        remain <= remain - 1'b1;
    end
  end

  assign busy = (remain != '0);

  // R8: a data block is only taken while a message is open
  assert_dat_in_msg_R8: assert property (@(posedge clk) disable iff (rst)
    (tick && dat_go) |-> busy);

  // R9: a slot taken by another source leaves the remaining count intact
  assert_ufc_resume_R9: assert property (@(posedge clk) disable iff (rst)
    (tick && !hdr_go && !dat_go) |=> $stable(remain));

endmodule

// File: rtl/tx_arb_prio.sv
module tx_arb_prio #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [N:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_rank
    assign seen[i+1] = seen[i] | req[i];
    assign gnt[i]    = req[i] & ~seen[i];
  end

endmodule

// File: rtl/tx_blk_arbiter.sv
module tx_blk_arbiter
  import tx_arb_pkg::*;
#(
  parameter int PAUSE_W   = 8,
  parameter int LEN_W     = 8,
  parameter int BLK_OCT   = 8,
  parameter int KT_W      = 4,
  parameter int UKB_TYPES = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               slot_tick,
  input  logic               cc_req,
  input  logic               nr_req,
  input  logic               cb_req,
  input  logic               nfc_req,
  input  logic [PAUSE_W-1:0] nfc_pause,
  input  logic               ufc_req,
  input  logic [LEN_W-1:0]   ufc_len,
  input  logic               ukb_req,
  input  logic [KT_W-1:0]    ukb_type,
  input  logic               data_req,
  output logic [N_SRC-1:0]   grant,
  output logic [3:0]         blk_sel
);
  localparam logic [KT_W-1:0] UKB_LIM = KT_W'(UKB_TYPES);

  logic             pause_hold;
  logic             ufc_busy;
  logic             data_hold;
  logic [N_SRC-1:0] req_vec;
  logic [N_SRC-1:0] gnt_nxt;
  blk_e             sel_nxt;
  logic [N_SRC-1:0] grant_q;
  blk_e             sel_q;

  assign data_hold = pause_hold | ufc_busy;

  always_comb begin
    req_vec    = '0;
    req_vec[0] = cc_req;
    req_vec[1] = nr_req;
    req_vec[2] = cb_req;
    req_vec[3] = nfc_req;
    req_vec[4] = ufc_req | ufc_busy;
    req_vec[5] = ukb_req & (ukb_type < UKB_LIM);
    req_vec[6] = data_req & ~data_hold;
    req_vec[7] = 1'b1;
  end

  tx_arb_prio #(.N(N_SRC)) u_prio (
    .req (req_vec),
    .gnt (gnt_nxt)
  );

  always_comb begin
    sel_nxt = BLK_IDLE;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (gnt_nxt[i]) sel_nxt = src_to_blk(i, ufc_busy);
  end

  tx_arb_pause #(.PAUSE_W(PAUSE_W)) u_pause (
    .clk       (clk),
    .rst       (rst),
    .tick      (slot_tick),
    .load      (gnt_nxt[3]),
    .pause_val (nfc_pause),
    .hold      (pause_hold)
  );

  tx_arb_ufc #(.LEN_W(LEN_W), .BLK_OCT(BLK_OCT)) u_ufc (
    .clk    (clk),
    .rst    (rst),
    .tick   (slot_tick),
    .hdr_go (gnt_nxt[4] & ~ufc_busy),
    .dat_go (gnt_nxt[4] & ufc_busy),
    .len_m1 (ufc_len),
    .busy   (ufc_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= N_SRC'(1) << (N_SRC - 1);
      sel_q   <= BLK_IDLE;
    end else if (slot_tick) begin
      grant_q <= gnt_nxt;
      sel_q   <= sel_nxt;
    end
  end

  assign grant   = grant_q;
  assign blk_sel = sel_q;

  // R3: exactly one source owns every slot
  assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot(grant_q));

  // R3: no change between slot ticks
  assert_hold_between_R3: assert property (@(posedge clk) disable iff (rst)
    (!slot_tick) |=> ($stable(grant_q) && $stable(sel_q)));

  // R2: clock compensation always wins its slot
  assert_cc_first_R2: assert property (@(posedge clk) disable iff (rst)
    (slot_tick && cc_req) |=> (grant_q[0] && sel_q == BLK_CC));

  // R4: nothing pending means idle
  assert_idle_fill_R4: assert property (@(posedge clk) disable iff (rst)
    (slot_tick && !cc_req && !nr_req && !cb_req && !nfc_req && !ufc_req
     && !ufc_busy && !ukb_req && !data_req) |=> grant_q[7]);

  // R5: frame data never goes out while a countdown holds it
  assert_no_data_in_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (slot_tick && data_hold) |=> !grant_q[6]);

  // R10: an out-of-range K-block type never earns a grant
  assert_ukb_range_R10: assert property (@(posedge clk) disable iff (rst)
    (slot_tick && ukb_type >= UKB_LIM) |=> !grant_q[5]);

endmodule

// File: tb/tx_blk_arbiter_bench.sv
module tx_blk_arbiter_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic       slot_tick;
  logic       cc_req, nr_req, cb_req, nfc_req, ufc_req, ukb_req, data_req;
  logic [7:0] nfc_pause, ufc_len;
  logic [3:0] ukb_type;
  logic [7:0] grant;
  logic [3:0] blk_sel;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic [3:0] code;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  logic pend = 1'b0;

  always #2 clk = ~clk;

  tx_blk_arbiter u_tx_blk_arbiter (
    .clk       (clk),
    .rst       (rst),
    .slot_tick (slot_tick),
    .cc_req    (cc_req),
    .nr_req    (nr_req),
    .cb_req    (cb_req),
    .nfc_req   (nfc_req),
    .nfc_pause (nfc_pause),
    .ufc_req   (ufc_req),
    .ufc_len   (ufc_len),
    .ukb_req   (ukb_req),
    .ukb_type  (ukb_type),
    .data_req  (data_req),
    .grant     (grant),
    .blk_sel   (blk_sel)
  );

  function automatic logic [7:0] code_to_grant(input logic [3:0] c);
    case (c)
      4'd0: return 8'h01;
      4'd1: return 8'h02;
      4'd2: return 8'h04;
      4'd3: return 8'h08;
      4'd4, 4'd5: return 8'h10;
      4'd6: return 8'h20;
      4'd7: return 8'h40;
      default: return 8'h80;
    endcase
  endfunction

  task automatic check(input logic [3:0] exp_code, input string tag);
    logic [7:0] eg;
    eg = code_to_grant(exp_code);
    n_cmp++;
    if (blk_sel !== exp_code || grant !== eg) begin
      n_bad++;
      $display("FAIL %s: sel=%0d grant=%02h expected sel=%0d grant=%02h",
               tag, blk_sel, grant, exp_code, eg);
    end
  endtask

  // monitor: pops one expectation per slot, half a cycle after the tick edge
  always @(posedge clk) pend <= slot_tick;
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R3: unexpected slot result sel=%0d expected none", blk_sel);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.code, e.tag);
      end
    end
  end

  task automatic clear_reqs();
    cc_req = 0; nr_req = 0; cb_req = 0; nfc_req = 0; ufc_req = 0;
    ukb_req = 0; data_req = 0; nfc_pause = 0; ufc_len = 0; ukb_type = 0;
  endtask

  // driver: applies one slot of requests and queues the expected block kind
  task automatic slot(input logic cc, input logic nr, input logic cb,
                      input logic nfc, input logic [7:0] pz,
                      input logic ufc, input logic [7:0] ul,
                      input logic ukb, input logic [3:0] ut,
                      input logic dat, input logic [3:0] exp_code,
                      input string tag);
    exp_t e;
    cc_req = cc; nr_req = nr; cb_req = cb; nfc_req = nfc; nfc_pause = pz;
    ufc_req = ufc; ufc_len = ul; ukb_req = ukb; ukb_type = ut; data_req = dat;
    slot_tick = 1'b1;
    e.code = exp_code; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    slot_tick = 1'b0;
    clear_reqs();
    @(negedge clk);
  endtask

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; slot_tick = 1'b0; clear_reqs();
    repeat (3) @(negedge clk);
    check(4'd8, "R1 reset state");
    rst = 1'b0;
    @(negedge clk);
    check(4'd8, "R1 after reset release");

    // R4 / R2 basic
    slot(0,0,0,0,0, 0,0, 0,0, 0, 4'd8, "R4 nothing requests");
    slot(0,0,0,0,0, 0,0, 0,0, 1, 4'd7, "R2 data alone");
    slot(1,1,1,0,0, 0,0, 1,3, 1, 4'd0, "R2 cc beats all");
    slot(0,1,1,0,0, 0,0, 1,3, 1, 4'd1, "R2 nr next");
    slot(0,0,1,0,0, 0,0, 1,3, 1, 4'd2, "R2 cb next");
    slot(0,0,0,1,0, 0,0, 1,3, 1, 4'd3, "R2 nfc next");
    slot(0,0,0,0,0, 0,0, 1,3, 1, 4'd6, "R2 ukb over data");
    slot(0,0,0,0,0, 0,0, 0,0, 1, 4'd7, "R6 pause 0 no hold");
    slot(0,0,0,0,0, 1,0, 1,3, 1, 4'd4, "R2 ufc over ukb");
    slot(0,0,0,0,0, 0,0, 1,3, 1, 4'd5, "R8 single data block");
    slot(0,0,0,0,0, 0,0, 0,0, 1, 4'd7, "R8 len0 message done");

    // R3: no change between ticks even when requests move
    cc_req = 1'b1; nr_req = 1'b1;
    repeat (3) @(negedge clk);
    check(4'd7, "R3 stable without tick");
    clear_reqs();

    // R5: pause 3
    slot(0,0,0,1,8'd3, 0,0, 0,0, 1, 4'd3, "R5 nfc pause 3");
    slot(0,0,0,0,0, 0,0, 0,0, 1, 4'd8, "R5 hold slot 1");
    slot(0,0,0,0,0, 0,0, 0,0, 1, 4'd8, "R5 hold slot 2");
    slot(0,0,0,0,0, 0,0, 0,0, 1, 4'd8, "R5 hold slot 3");
    slot(0,0,0,0,0, 0,0, 0,0, 1, 4'd7, "R5 data after hold");

    // R5: K-block still served during pause, countdown continues
    slot(0,0,0,1,8'd2, 0,0, 0,0, 1, 4'd3, "R5 nfc pause 2");
    slot(0,0,0,0,0, 0,0, 1,8, 1, 4'd6, "R5 ukb during hold");
    slot(0,0,0,0,0, 0,0, 0,0, 1, 4'd8, "R5 hold continues");
    slot(0,0,0,0,0, 0,0, 0,0, 1, 4'd7, "R5 hold over");

    // R7: indefinite pause
    slot(0,0,0,1,8'd255, 0,0, 0,0, 1, 4'd3, "R7 nfc xoff");
    for (int i = 0; i < 6; i++)
      slot(0,0,0,0,0, 0,0, 0,0, 1, 4'd8, "R7 xoff holds");
    slot(0,0,0,1,8'd1, 0,0, 0,0, 1, 4'd3, "R7 nfc release 1");
    slot(0,0,0,0,0, 0,0, 0,0, 1, 4'd8, "R7 short hold");
    slot(0,0,0,0,0, 0,0, 0,0, 1, 4'd7, "R7 data back");

    // R8 / R9: 20 octets = 3 data blocks, interrupted, new request ignored
    slot(0,0,0,0,0, 1,8'd19, 0,0, 1, 4'd4, "R8 header len 19");
    slot(0,0,0,0,0, 1,8'd200, 0,0, 1, 4'd5, "R9 ufc_req ignored in msg");
    slot(1,0,0,0,0, 0,0, 0,0, 1, 4'd0, "R9 cc cuts in");
    slot(0,0,0,0,0, 0,0, 0,0, 0, 4'd5, "R9 resume block 2");
    slot(0,0,0,0,0, 0,0, 0,0, 1, 4'd5, "R8 block 3");
    slot(0,0,0,0,0, 0,0, 0,0, 1, 4'd7, "R8 data after message");

    // R8: 9 octets = 2 blocks
    slot(0,0,0,0,0, 1,8'd8, 0,0, 1, 4'd4, "R8 header len 8");
    slot(0,0,0,0,0, 0,0, 0,0, 1, 4'd5, "R8 len8 block 1");
    slot(0,0,0,0,0, 0,0, 0,0, 1, 4'd5, "R8 len8 block 2");
    slot(0,0,0,0,0, 0,0, 0,0, 1, 4'd7, "R8 len8 done");

    // R8: 256 octets = 32 blocks
    slot(0,0,0,0,0, 1,8'd255, 0,0, 1, 4'd4, "R8 header len 255");
    for (int i = 0; i < 32; i++)
      slot(0,0,0,0,0, 0,0, 0,0, 1, 4'd5, "R8 len255 block");
    slot(0,0,0,0,0, 0,0, 0,0, 1, 4'd7, "R8 len255 done");

    // R10: K-block type range
    slot(0,0,0,0,0, 0,0, 1,4'd9, 1, 4'd7, "R10 type 9 ignored");
    slot(0,0,0,0,0, 0,0, 1,4'd15, 0, 4'd8, "R10 type 15 ignored");
    slot(0,0,0,0,0, 0,0, 1,4'd0, 1, 4'd6, "R10 type 0 served");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R3: %0d slots unreported expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule